// File: doc/BRIEF.md
# TFT Panel Power-Up Sequencer

This block brings a small TFT panel controller from cold to streaming. On a start pulse it holds the panel's active-low reset pin low for a fixed time, releases it for the same time, and then walks an internal table of entries. Each entry is a register write (an index message followed by a data message), an index-only message, a millisecond pause, or the end marker. Messages go out through a simple valid/done handshake to a serial register write master that sits beside this block. When the end marker is reached, frame streaming is enabled and a ready flag rises.

A stop pulse shuts the panel down in two steps. Streaming stops at once, and the controller clock enable is held for a further fixed number of milliseconds so that a frame already in flight can finish. All timed waits are counted in clock cycles from a clocks-per-millisecond parameter. A new start pulse at any time restarts the whole sequence from the reset pulse.

Top module: `lcd_init_seq`

## Requirements
- R1: While rstN is low: panelRstN=0, ctrlClkEn=0, streamEn=0, ready=0 and msgValid=0.
- R2: In the cycle after start is sampled, panelRstN is 0 and ctrlClkEn is 1. panelRstN stays 0 for RESET_MS*CLKS_PER_MS cycles, then stays 1 for RESET_MS*CLKS_PER_MS+1 cycles before the first msgValid. No message is offered while panelRstN is 0.
- R3: While msgValid is high and msgDone is low, msgValid, msgKind and msgWord hold. A register write is an index message (msgKind=0, msgWord = register number zero-extended) followed, in the cycle after its done, by a data message (msgKind=1, msgWord = value).
- R4: Power phase, in order: reg 0x10=0x4444, 0x11=0x0001, 0x12=0x0003, 0x13=0x1119, 0x12=0x0013, pause 50 ms, 0x10=0x4440, 0x13=0x3119, pause 150 ms.
- R5: Between the done of one message and the next msgValid, msgValid is low for 1 cycle, 0 cycles from index to data of one write, and d*CLKS_PER_MS+2 cycles across a pause of d ms.
- R6: Window setup: reg 0x42=0xDB00, 0x44=0xAF00, 0x45=0xDB00 (end row 219 and end column 175 in the upper byte).
- R7: Display-on steps: reg 0x07=0x0045, pause 50 ms, 0x07=0x0065, 0x07=0x0067, pause 50 ms, 0x07=0x0077.
- R8: The last message is index-only with msgWord=0x0022. streamEn and ready are 0 one cycle after its done and 1 two cycles after; no message is offered while streamEn is 1.
- R9: After a stop pulse, streamEn, ready and msgValid are 0 on the next cycle. ctrlClkEn stays 1 for OFF_MS*CLKS_PER_MS cycles, then drops with panelRstN back at 0.
- R10: A start pulse during the sequence withdraws any offered message in the next cycle and restarts from the reset pulse and the first table entry.
- R11: When start and stop are sampled together, start wins: the sequence restarts and ctrlClkEn stays 1.
- R12: A stop pulse while idle changes no output.
- R13: Between the 150 ms pause and the window writes come: reg 0x01=0x101B, 0x02=0x0700, 0x03=0x6020, 0x04=0, 0x05=0, 0x08=0x0102, 0x09=0, 0x0B=0x4400, 0x0C=0x0110, 0x40=0, 0x41=0; between 0x42 and 0x44 comes 0x43=0. After 0x45 come 0x30..0x39 with 0x0000, 0x0704, 0x0107, 0x0704, 0x0107, 0x0002, 0x0707, 0x0503, 0x0000, 0x0000, then 0x21=0x00AF, 0x0C=0x0110, 0x10=0x4740, before the display-on steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: run or restart the power-up sequence |
| stop | input | 1 | Pulse: shut the panel down |
| msgDone | input | 1 | Serial master has finished the offered message |
| msgValid | output | 1 | A message is offered |
| msgKind | output | 1 | 0 = register index, 1 = register data |
| msgWord | output | 16 | Message payload |
| panelRstN | output | 1 | Active-low panel reset pin |
| ctrlClkEn | output | 1 | Clock enable of the panel controller |
| streamEn | output | 1 | Frame streaming enable |
| ready | output | 1 | Sequence finished, panel streaming |

## Verification
A table pointer that skips or repeats shows at once as a wrong msgWord or msgKind on the next offered message, and a message out of order is caught on the message it displaces. A timer loaded with the wrong limit changes the measured low-time of panelRstN, the length of a msgValid gap across a pause, or the time ctrlClkEn stays high after stop, each visible within that wait. A control state that misreads a start, stop or done shows in the cycle after the pulse as a message still offered, a reset pin still high, or streaming left on.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_INDEX = 2'd1,
    OP_DELAY = 2'd2,
    OP_END   = 2'd3
  } stepOpE;

  typedef struct packed {
    stepOpE      op;
    logic [7:0]  regIdx;
    logic [15:0] value;   // data word, or pause length in ms
  } stepT;

  typedef enum logic [1:0] {
    TMR_RESET = 2'd0,
    TMR_STEP  = 2'd1,
    TMR_OFF   = 2'd2
  } timerSelE;

  typedef struct packed {
    logic     ptrClr;
    logic     ptrInc;
    logic     timerArm;
    timerSelE timerSel;
  } ctrlStrobeT;

  localparam int STEP_COUNT = 45;

  function automatic stepT mkWrite(input logic [7:0] r, input logic [15:0] v);
    stepT s;
    s.op = OP_WRITE; s.regIdx = r; s.value = v;
    return s;
  endfunction

  function automatic stepT mkIndex(input logic [7:0] r);
    stepT s;
    s.op = OP_INDEX; s.regIdx = r; s.value = 16'h0000;
    return s;
  endfunction

  function automatic stepT mkPause(input logic [15:0] ms);
    stepT s;
    s.op = OP_DELAY; s.regIdx = 8'h00; s.value = ms;
    return s;
  endfunction

  function automatic stepT mkEnd();
    stepT s;
    s.op = OP_END; s.regIdx = 8'h00; s.value = 16'h0000;
    return s;
  endfunction

  // Power-up program; the order of entries is the behaviour.
  function automatic stepT stepAt(input logic [7:0] idx);
    case (idx)
      8'd0:  return mkWrite(8'h10, 16'h4444);
      8'd1:  return mkWrite(8'h11, 16'h0001);
      8'd2:  return mkWrite(8'h12, 16'h0003);
      8'd3:  return mkWrite(8'h13, 16'h1119);
      8'd4:  return mkWrite(8'h12, 16'h0013);
      8'd5:  return mkPause(16'd50);
      8'd6:  return mkWrite(8'h10, 16'h4440);
      8'd7:  return mkWrite(8'h13, 16'h3119);
      8'd8:  return mkPause(16'd150);
      8'd9:  return mkWrite(8'h01, 16'h101B);
      8'd10: return mkWrite(8'h02, 16'h0700);
      8'd11: return mkWrite(8'h03, 16'h6020);
      8'd12: return mkWrite(8'h04, 16'h0000);
      8'd13: return mkWrite(8'h05, 16'h0000);
      8'd14: return mkWrite(8'h08, 16'h0102);
      8'd15: return mkWrite(8'h09, 16'h0000);
      8'd16: return mkWrite(8'h0B, 16'h4400);
      8'd17: return mkWrite(8'h0C, 16'h0110);
      8'd18: return mkWrite(8'h40, 16'h0000);
      8'd19: return mkWrite(8'h41, 16'h0000);
      8'd20: return mkWrite(8'h42, {8'd219, 8'h00});
      8'd21: return mkWrite(8'h43, 16'h0000);
      8'd22: return mkWrite(8'h44, {8'd175, 8'h00});
      8'd23: return mkWrite(8'h45, {8'd219, 8'h00});
      8'd24: return mkWrite(8'h30, 16'h0000);
      8'd25: return mkWrite(8'h31, 16'h0704);
      8'd26: return mkWrite(8'h32, 16'h0107);
      8'd27: return mkWrite(8'h33, 16'h0704);
      8'd28: return mkWrite(8'h34, 16'h0107);
      8'd29: return mkWrite(8'h35, 16'h0002);
      8'd30: return mkWrite(8'h36, 16'h0707);
      8'd31: return mkWrite(8'h37, 16'h0503);
      8'd32: return mkWrite(8'h38, 16'h0000);
      8'd33: return mkWrite(8'h39, 16'h0000);
      8'd34: return mkWrite(8'h21, 16'd175);
      8'd35: return mkWrite(8'h0C, 16'h0110);
      8'd36: return mkWrite(8'h10, 16'h4740);
      8'd37: return mkWrite(8'h07, 16'h0045);
      8'd38: return mkPause(16'd50);
      8'd39: return mkWrite(8'h07, 16'h0065);
      8'd40: return mkWrite(8'h07, 16'h0067);
      8'd41: return mkPause(16'd50);
      8'd42: return mkWrite(8'h07, 16'h0077);
      8'd43: return mkIndex(8'h22);
      default: return mkEnd();
    endcase
  endfunction

endpackage

// File: rtl/lcd_init_dp.sv
module lcd_init_dp
  import lcd_init_pkg::*;
#(
  parameter int CLKS_PER_MS  = 1000,
  parameter int RESET_MS     = 10,
  parameter int OFF_MS       = 20,
  parameter int MAX_PAUSE_MS = 255
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strb,
  output stepT       curStep,
  output logic       timerZero
);

  localparam int PTR_W       = $clog2(STEP_COUNT);
  localparam int MAX_MS_A    = (RESET_MS > OFF_MS) ? RESET_MS : OFF_MS;
  localparam int MAX_MS      = (MAX_MS_A > MAX_PAUSE_MS) ? MAX_MS_A : MAX_PAUSE_MS;
  localparam int TIMER_W     = $clog2(MAX_MS * CLKS_PER_MS + 1);
  localparam int RESET_LIMIT = RESET_MS * CLKS_PER_MS;
  localparam int OFF_LIMIT   = OFF_MS * CLKS_PER_MS;

  logic [PTR_W-1:0]   stepPtr;
  logic [TIMER_W-1:0] remaining;
  logic [TIMER_W-1:0] limitSel;

  // Step pointer into the program table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stepPtr <= '0;
    else if (strb.ptrClr) stepPtr <= '0;
    else if (strb.ptrInc) stepPtr <= stepPtr + PTR_W'(1);
  end

  always_comb curStep = stepAt(8'(stepPtr));

  // Wait length for the armed timer
  always_comb begin
    case (strb.timerSel)
      TMR_STEP: limitSel = TIMER_W'(32'(curStep.value) * CLKS_PER_MS);
      TMR_OFF:  limitSel = TIMER_W'(OFF_LIMIT);
      default:  limitSel = TIMER_W'(RESET_LIMIT);
    endcase
  end

  // Down-counter: a state armed with limit N is held exactly N cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                remaining <= '0;
    else if (strb.timerArm)   remaining <= limitSel - TIMER_W'(1);
    else if (remaining != '0) remaining <= remaining - TIMER_W'(1);
  end

  assign timerZero = (remaining == '0);

  assert_ptr_in_table_R4: assert property (@(posedge clk) disable iff (!rstN)
    32'(stepPtr) < STEP_COUNT);

  assert_pause_fits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.timerArm && strb.timerSel == TMR_STEP) |->
      (curStep.op == OP_DELAY && 32'(curStep.value) <= MAX_PAUSE_MS && curStep.value != 16'd0));

  assert_arm_only_when_idle_timer_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.timerArm && strb.timerSel == TMR_RESET && !strb.ptrClr) |-> timerZero);

endmodule

// File: rtl/lcd_init_ctrl.sv
module lcd_init_ctrl
  import lcd_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stop,
  input  logic        msgDone,
  input  stepT        curStep,
  input  logic        timerZero,
  output ctrlStrobeT  strb,
  output logic        msgValid,
  output logic        msgKind,
  output logic [15:0] msgWord,
  output logic        panelRstN,
  output logic        ctrlClkEn,
  output logic        streamEn,
  output logic        ready
);

  typedef enum logic [3:0] {
    S_IDLE     = 4'd0,
    S_RST_LOW  = 4'd1,
    S_RST_HIGH = 4'd2,
    S_FETCH    = 4'd3,
    S_SEND_IDX = 4'd4,
    S_SEND_DAT = 4'd5,
    S_PAUSE    = 4'd6,
    S_RUN      = 4'd7,
    S_OFF      = 4'd8
  } seqStateE;

  seqStateE state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    strb.ptrClr   = 1'b0;
    strb.ptrInc   = 1'b0;
    strb.timerArm = 1'b0;
    strb.timerSel = TMR_RESET;
    case (state)
      S_RST_LOW: if (timerZero) begin
        stateNext     = S_RST_HIGH;
        strb.timerArm = 1'b1;
      end
      S_RST_HIGH: if (timerZero) stateNext = S_FETCH;
      S_FETCH: begin
        case (curStep.op)
          OP_WRITE, OP_INDEX: stateNext = S_SEND_IDX;
          OP_DELAY: begin
            stateNext     = S_PAUSE;
            strb.timerArm = 1'b1;
            strb.timerSel = TMR_STEP;
          end
          default: stateNext = S_RUN;
        endcase
      end
      S_SEND_IDX: if (msgDone) begin
        if (curStep.op == OP_WRITE) stateNext = S_SEND_DAT;
        else begin
          stateNext   = S_FETCH;
          strb.ptrInc = 1'b1;
        end
      end
      S_SEND_DAT: if (msgDone) begin
        stateNext   = S_FETCH;
        strb.ptrInc = 1'b1;
      end
      S_PAUSE: if (timerZero) begin
        stateNext   = S_FETCH;
        strb.ptrInc = 1'b1;
      end
      S_OFF: if (timerZero) stateNext = S_IDLE;
      default: ;
    endcase

    // Shutdown: streaming off now, controller clock after the drain wait
    if (stop && state != S_IDLE && state != S_OFF) begin
      stateNext     = S_OFF;
      strb.ptrInc   = 1'b0;
      strb.timerArm = 1'b1;
      strb.timerSel = TMR_OFF;
    end

    // Restart has priority over everything
    if (start) begin
      stateNext     = S_RST_LOW;
      strb.ptrClr   = 1'b1;
      strb.ptrInc   = 1'b0;
      strb.timerArm = 1'b1;
      strb.timerSel = TMR_RESET;
    end
  end

  assign msgValid  = (state == S_SEND_IDX) || (state == S_SEND_DAT);
  assign msgKind   = (state == S_SEND_DAT);
  assign msgWord   = (state == S_SEND_DAT) ? curStep.value : {8'h00, curStep.regIdx};
  assign panelRstN = (state != S_IDLE) && (state != S_RST_LOW);
  assign ctrlClkEn = (state != S_IDLE);
  assign streamEn  = (state == S_RUN);
  assign ready     = (state == S_RUN);

  assert_msg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgDone && !start && !stop) |=>
      (msgValid && $stable(msgWord) && $stable(msgKind)));

  assert_data_follows_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgKind && msgDone && curStep.op == OP_WRITE && !start && !stop) |=>
      (msgValid && msgKind));

  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    !panelRstN |-> !msgValid);

  assert_stream_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    streamEn |-> !msgValid);

  assert_stop_drops_stream_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !start) |=> (!streamEn && !ready && !msgValid));

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!panelRstN && ctrlClkEn && !ready && !msgValid));

  assert_clk_drop_after_drain_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlClkEn) |-> ($past(state) == S_OFF && !panelRstN));

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int CLKS_PER_MS  = 1000,
  parameter int RESET_MS     = 10,
  parameter int OFF_MS       = 20,
  parameter int MAX_PAUSE_MS = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stop,
  input  logic        msgDone,
  output logic        msgValid,
  output logic        msgKind,
  output logic [15:0] msgWord,
  output logic        panelRstN,
  output logic        ctrlClkEn,
  output logic        streamEn,
  output logic        ready
);

  ctrlStrobeT strb;
  stepT       curStep;
  logic       timerZero;

  lcd_init_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stop      (stop),
    .msgDone   (msgDone),
    .curStep   (curStep),
    .timerZero (timerZero),
    .strb      (strb),
    .msgValid  (msgValid),
    .msgKind   (msgKind),
    .msgWord   (msgWord),
    .panelRstN (panelRstN),
    .ctrlClkEn (ctrlClkEn),
    .streamEn  (streamEn),
    .ready     (ready)
  );

  lcd_init_dp #(
    .CLKS_PER_MS  (CLKS_PER_MS),
    .RESET_MS     (RESET_MS),
    .OFF_MS       (OFF_MS),
    .MAX_PAUSE_MS (MAX_PAUSE_MS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .curStep   (curStep),
    .timerZero (timerZero)
  );

endmodule

// File: tb/test_lcd_init_seq.sv
module test_lcd_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 8;
  localparam int RST_MS     = 10;
  localparam int OFF_MS     = 20;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN, start, stop, msgDone;
  logic msgValid, msgKind, panelRstN, ctrlClkEn, streamEn, ready;
  logic [15:0] msgWord;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int    expKind[$];
  int    expWord[$];
  int    expGap[$];
  string expTag[$];
  int    pendGap;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_init_seq #(
    .CLKS_PER_MS (CPM),
    .RESET_MS    (RST_MS),
    .OFF_MS      (OFF_MS)
  ) i_lcd_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .msgDone(msgDone),
    .msgValid(msgValid), .msgKind(msgKind), .msgWord(msgWord),
    .panelRstN(panelRstN), .ctrlClkEn(ctrlClkEn), .streamEn(streamEn), .ready(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---- reference program built from the requirements ----
  task automatic addWrite(input int r, input int v, input string tag);
    expKind.push_back(0); expWord.push_back(r); expGap.push_back(pendGap); expTag.push_back(tag);
    expKind.push_back(1); expWord.push_back(v); expGap.push_back(0);       expTag.push_back(tag);
    pendGap = 1;
  endtask

  task automatic addPause(input int ms);
    pendGap = ms * CPM + 2;
  endtask

  task automatic buildProgram();
    pendGap = 0;
    addWrite('h10, 'h4444, "R4"); addWrite('h11, 'h0001, "R4"); addWrite('h12, 'h0003, "R4");
    addWrite('h13, 'h1119, "R4"); addWrite('h12, 'h0013, "R4");
    addPause(50);
    addWrite('h10, 'h4440, "R4"); addWrite('h13, 'h3119, "R4");
    addPause(150);
    addWrite('h01, 'h101B, "R13"); addWrite('h02, 'h0700, "R13"); addWrite('h03, 'h6020, "R13");
    addWrite('h04, 0, "R13"); addWrite('h05, 0, "R13"); addWrite('h08, 'h0102, "R13");
    addWrite('h09, 0, "R13"); addWrite('h0B, 'h4400, "R13"); addWrite('h0C, 'h0110, "R13");
    addWrite('h40, 0, "R13"); addWrite('h41, 0, "R13");
    addWrite('h42, 219 * 256, "R6"); addWrite('h43, 0, "R13");
    addWrite('h44, 175 * 256, "R6"); addWrite('h45, 219 * 256, "R6");
    addWrite('h30, 'h0000, "R13"); addWrite('h31, 'h0704, "R13"); addWrite('h32, 'h0107, "R13");
    addWrite('h33, 'h0704, "R13"); addWrite('h34, 'h0107, "R13"); addWrite('h35, 'h0002, "R13");
    addWrite('h36, 'h0707, "R13"); addWrite('h37, 'h0503, "R13"); addWrite('h38, 'h0000, "R13");
    addWrite('h39, 'h0000, "R13");
    addWrite('h21, 175, "R13"); addWrite('h0C, 'h0110, "R13"); addWrite('h10, 'h4740, "R13");
    addWrite('h07, 'h0045, "R7");
    addPause(50);
    addWrite('h07, 'h0065, "R7"); addWrite('h07, 'h0067, "R7");
    addPause(50);
    addWrite('h07, 'h0077, "R7");
    expKind.push_back(0); expWord.push_back('h22); expGap.push_back(pendGap); expTag.push_back("R8");
  endtask

  // ---- stimulus helpers ----
  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic measureReset();
    int lo = 0;
    int hi = 0;
    chk("R2 clock enable on", int'(ctrlClkEn), 1);
    while (!panelRstN && lo < 100000) begin
      if (msgValid) chk("R2 message during reset", 1, 0);
      lo++; @(negedge clk);
    end
    chk("R2 reset low cycles", lo, RST_MS * CPM);
    while (panelRstN && !msgValid && hi < 100000) begin hi++; @(negedge clk); end
    chk("R2 reset high cycles", hi, RST_MS * CPM + 1);
  endtask

  // Acts as the serial master; starts at a negedge, leaves at the negedge after a done
  task automatic serve(input int upTo);
    int idx = 0;
    int lows = 0;
    while (idx < upTo) begin
      if (!msgValid) begin
        lows++;
        @(negedge clk);
      end else begin
        int lat;
        lat = (idx * 7) % 4;
        chk({expTag[idx], " R5 gap"}, lows, expGap[idx]);
        chk({expTag[idx], " R3 kind"}, int'(msgKind), expKind[idx]);
        chk({expTag[idx], " word"}, int'(msgWord), expWord[idx]);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk("R3 hold while waiting", int'(msgValid) * 65536 + int'(msgWord), 65536 + expWord[idx]);
        end
        msgDone = 1'b1;
        @(negedge clk);
        msgDone = 1'b0;
        idx++;
        lows = 0;
      end
    end
  endtask

  task automatic checkFinish();
    chk("R8 stream not yet on", int'(streamEn) * 2 + int'(ready), 0);
    @(negedge clk);
    chk("R8 stream on", int'(streamEn), 1);
    chk("R8 ready on", int'(ready), 1);
    repeat (5) @(negedge clk);
    chk("R8 no further message", int'(msgValid), 0);
  endtask

  // Per-cycle invariant checks
  always @(negedge clk) begin
    if (rstN === 1'b1 && !finished) begin
      if (streamEn && msgValid) chk("R8 message while streaming", 1, 0);
      if (!panelRstN && msgValid) chk("R2 message while panel reset", 1, 0);
    end
  end

  initial begin
    int n;
    rstN = 1'b0; start = 1'b0; stop = 1'b0; msgDone = 1'b0;
    buildProgram();
    repeat (3) @(negedge clk);
    chk("R1 panelRstN", int'(panelRstN), 0);
    chk("R1 ctrlClkEn", int'(ctrlClkEn), 0);
    chk("R1 streamEn", int'(streamEn), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 msgValid", int'(msgValid), 0);
    rstN = 1'b1;

    // R12: stop while idle
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R12 clk en stays off", int'(ctrlClkEn), 0);
    chk("R12 panel stays reset", int'(panelRstN), 0);
    @(negedge clk);
    chk("R12 no message", int'(msgValid), 0);

    // Full sequence
    pulseStart();
    measureReset();
    serve(expKind.size());
    checkFinish();

    // R9: shutdown
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R9 stream off", int'(streamEn), 0);
    chk("R9 ready off", int'(ready), 0);
    chk("R9 clock kept", int'(ctrlClkEn), 1);
    n = 0;
    while (ctrlClkEn && n < 100000) begin n++; @(negedge clk); end
    chk("R9 drain cycles", n, OFF_MS * CPM);
    chk("R9 panel reset after off", int'(panelRstN), 0);

    // R10: restart in the middle
    pulseStart();
    measureReset();
    serve(11);
    while (!msgValid) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 message withdrawn", int'(msgValid), 0);
    chk("R10 panel reset again", int'(panelRstN), 0);
    measureReset();
    serve(expKind.size());
    checkFinish();

    // R11: start and stop together
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    chk("R11 panel reset restarts", int'(panelRstN), 0);
    chk("R11 clock kept on", int'(ctrlClkEn), 1);
    chk("R11 stream off", int'(streamEn), 0);
    measureReset();
    serve(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule